// File: doc/BRIEF.md
# Parallel Single-Slope Conversion Back-End with Four-Lane Serializer

This block is the digital half of a bank of single-slope converters. One free-running code counter, shared by every channel, steps once per clock while an external voltage ramp climbs. Each channel has a comparator outside the block that goes high once the ramp passes the level held in that channel. On the first clean rising edge of its comparator, the channel freezes the counter value into its own result register. That value is the conversion result.

A pulse on the start input opens a conversion. The counter then sweeps its full range, and the ramp-active output stays high for the whole sweep. When the sweep ends, every result is copied into a set of lane shift registers and a one-cycle done pulse is given. The results leave on four serial lanes at one bit per clock, and only while read enable is high. The channel count, code width, lane count and synchronizer depth are parameters. The defaults are 32 channels, 11-bit codes and 4 lanes.

Top module: `ssadc_backend`

## Requirements
- R1: While reset is held, ramp_on_o, done_o and all lanes of sdata_o are 0.
- R2: A start pulse seen at a rising edge while the block is idle raises ramp_on_o in the next cycle. The counter begins at 0 and advances one step per clock. ramp_on_o stays high for exactly 2^CW cycles (2048 by default).
- R3: Each comparator input passes through a two-flop synchronizer. If a comparator is first sampled high at the k-th rising edge after the edge that raised ramp_on_o, its result word is k+1. The result is clipped to 2047.
- R4: Only the first synchronized rising edge of a comparator during a sweep is captured. A drop and a later rise within the same sweep leave the result unchanged.
- R5: A channel whose comparator never rises during the sweep reports full scale, 2047.
- R6: done_o is high for exactly one cycle, in the cycle right after ramp_on_o falls. The first bit of every lane is already present on sdata_o in that cycle.
- R7: Lane k carries 88 bits: channels 8k up to 8k+7 in ascending order, each as 11 bits with the most significant bit first. After all 88 bits have been shifted, the lane reads 0.
- R8: Lanes advance by one bit only on rising edges where rd_en_i is high. Otherwise sdata_o holds its value.
- R9: Start is ignored while a sweep or a shift-out is in progress. After the 88th shift the block is idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (counter and serializer) |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Opens a conversion when the block is idle |
| cmp_i | input | NCH | Asynchronous comparator outputs, one per channel |
| rd_en_i | input | 1 | Enables one bit shift per clock on all lanes |
| ramp_on_o | output | 1 | High while the ramp is sweeping and the counter runs |
| done_o | output | 1 | One-cycle pulse when results are loaded into the lanes |
| sdata_o | output | NLANE | Serial result lanes, MSB first |

## Verification
Each result falls due at a fixed number of clock edges after its stimulus. ramp_on_o rises one edge after start and falls 2048 edges later. A comparator rise that is sampled at edge k turns into code k+1, because two synchronizer edges and one capture edge lie between them. done_o and the first lane bit appear one edge after the sweep ends. Every later lane bit needs one edge with read enable high. The bench drives all inputs on falling edges and samples on falling edges. It counts the sweep index j at each falling edge, raises a comparator at j = t and expects code t+2. It reads one lane bit per falling edge, and during paused stretches it checks that the lanes hold their values.

// File: rtl/ssadc_pkg.sv
`timescale 1ns/1ps
// Shared types for the single-slope conversion back-end.
package ssadc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SWEEP = 2'd1,
      PH_DRAIN = 2'd2
   } phase_e;
endpackage

// File: rtl/ssadc_edge_sync.sv
`timescale 1ns/1ps
// Per-channel synchronizer followed by rising-edge detection.
module ssadc_edge_sync #(
   parameter int NCH    = 32,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] async_i,
   output logic [NCH-1:0] rise_o
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      // STAGES synchronizing flops plus one history flop
      logic [STAGES:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-1:0], async_i[g]};
      end
      assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
   end
endmodule

// File: rtl/ssadc_capture.sv
`timescale 1ns/1ps
// One result register per channel, written on the first rising edge in a sweep.
module ssadc_capture #(
   parameter int NCH = 32,
   parameter int CW  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              arm_i,
   input  logic [NCH-1:0]    rise_i,
   input  logic [CW-1:0]     count_i,
   output logic [NCH*CW-1:0] words_o
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic          hit_q;
      logic [CW-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q  <= 1'b0;
            code_q <= '0;
         end else if (clear_i) begin
            hit_q  <= 1'b0;
            code_q <= '0;
         end else if (arm_i && rise_i[g] && !hit_q) begin
            hit_q  <= 1'b1;
            code_q <= count_i;
         end
      end
      // a channel that never fired reads full scale
      assign words_o[g*CW +: CW] = hit_q ? code_q : {CW{1'b1}};
   end
endmodule

// File: rtl/ssadc_lanes.sv
`timescale 1ns/1ps
// Parallel-load, MSB-first shift registers, one per lane.
module ssadc_lanes #(
   parameter int NCH   = 32,
   parameter int CW    = 11,
   parameter int NLANE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [NCH*CW-1:0] words_i,
   output logic [NLANE-1:0]  sdata_o
);
   localparam int WPL   = NCH / NLANE;
   localparam int LBITS = WPL * CW;

   for (genvar k = 0; k < NLANE; k++) begin : g_lane
      logic [LBITS-1:0] pack;
      logic [LBITS-1:0] sr_q;
      always_comb begin
         pack = '0;
         for (int w = 0; w < WPL; w++) begin
            pack[LBITS-1-w*CW -: CW] = words_i[(k*WPL+w)*CW +: CW];
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sr_q <= '0;
         else if (load_i)  sr_q <= pack;
         else if (shift_i) sr_q <= {sr_q[LBITS-2:0], 1'b0};
      end
      assign sdata_o[k] = sr_q[LBITS-1];
   end
endmodule

// File: rtl/ssadc_backend.sv
`timescale 1ns/1ps
// Shared-counter single-slope conversion back-end with lane serializer.
module ssadc_backend
   import ssadc_pkg::*;
#(
   parameter int NCH         = 32,
   parameter int CW          = 11,
   parameter int NLANE       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [NCH-1:0]   cmp_i,
   input  logic             rd_en_i,
   output logic             ramp_on_o,
   output logic             done_o,
   output logic [NLANE-1:0] sdata_o
);
   localparam int            WPL     = NCH / NLANE;
   localparam int            LBITS   = WPL * CW;
   localparam int            BCW     = $clog2(LBITS);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
   localparam logic [BCW-1:0] BIT_LAST = BCW'(LBITS - 1);

   // elaboration-time parameter checks
   if (NCH % NLANE != 0) begin : g_bad_split
      $error("NCH must be a multiple of NLANE");
   end
   if (CW < 2) begin : g_bad_cw
      $error("CW must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   phase_e            phase_q;
   logic [CW-1:0]     cnt_q;
   logic [BCW-1:0]    bit_q;
   logic              done_q;
   logic [NCH-1:0]    rise;
   logic [NCH*CW-1:0] words;
   logic              accept, sweeping, draining, last_cnt, load, shift;

   assign accept   = (phase_q == PH_IDLE) && start_i;
   assign sweeping = (phase_q == PH_SWEEP);
   assign draining = (phase_q == PH_DRAIN);
   assign last_cnt = sweeping && (cnt_q == CNT_MAX);
   assign load     = last_cnt;
   assign shift    = draining && rd_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (start_i) begin
               phase_q <= PH_SWEEP;
               cnt_q   <= '0;
            end
            PH_SWEEP: if (cnt_q == CNT_MAX) begin
               phase_q <= PH_DRAIN;
               done_q  <= 1'b1;
               bit_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
            PH_DRAIN: if (rd_en_i) begin
               if (bit_q == BIT_LAST) phase_q <= PH_IDLE;
               else                   bit_q   <= bit_q + 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   ssadc_edge_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .rise_o(rise)
   );

   ssadc_capture #(.NCH(NCH), .CW(CW)) i_cap (
      .clk(clk), .rst_n(rst_n), .clear_i(accept), .arm_i(sweeping),
      .rise_i(rise), .count_i(cnt_q), .words_o(words)
   );

   ssadc_lanes #(.NCH(NCH), .CW(CW), .NLANE(NLANE)) i_lanes (
      .clk(clk), .rst_n(rst_n), .load_i(load), .shift_i(shift),
      .words_i(words), .sdata_o(sdata_o)
   );

   assign ramp_on_o = sweeping;
   assign done_o    = done_q;
endmodule

// File: rtl/ssadc_backend_chk.sv
`timescale 1ns/1ps
// Temporal checks for the conversion back-end.
module ssadc_backend_chk #(
   parameter int CW    = 11,
   parameter int NLANE = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             rd_en_i,
   input logic             ramp_on_o,
   input logic             done_o,
   input logic [NLANE-1:0] sdata_o,
   input logic             draining
);
   localparam logic [CW:0] SWEEP_CYC = (CW+1)'(1) << CW;

   logic [CW:0] sweep_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sweep_len_q <= '0;
      else if (ramp_on_o) sweep_len_q <= sweep_len_q + 1'b1;
      else                sweep_len_q <= '0;
   end

   AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ramp_on_o) |-> sweep_len_q == SWEEP_CYC);                 // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                             // R6
   AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(ramp_on_o) && !ramp_on_o));                    // R6
   AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (draining && !rd_en_i) |=> $stable(sdata_o));                    // R8
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (draining && start_i) |=> !ramp_on_o);                           // R9
   AST_SWEEP_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_on_o) |-> $past(start_i));                            // R2
endmodule

bind ssadc_backend ssadc_backend_chk #(.CW(CW), .NLANE(NLANE)) i_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_en_i(rd_en_i),
   .ramp_on_o(ramp_on_o), .done_o(done_o), .sdata_o(sdata_o),
   .draining(draining)
);

// File: tb/test_ssadc_backend.sv
`timescale 1ns/1ps
module test_ssadc_backend;
   localparam int NCH = 32, CW = 11, NLANE = 4, WPL = 8, LBITS = 88;
   localparam int FULL = 2047, SWEEP = 2048;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_en = 1'b0;
   logic [NCH-1:0] cmp = '0;
   logic ramp_on, done;
   logic [NLANE-1:0] sdata;
   int checks = 0, errors = 0;
   logic [LBITS-1:0] got [NLANE];

   always #2.5 clk = ~clk;

   ssadc_backend i_ssadc_backend (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
      .rd_en_i(rd_en), .ramp_on_o(ramp_on), .done_o(done), .sdata_o(sdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // sweep index at which a channel's comparator goes high, -1 = never
   function automatic int thr(input int pat, input int ch);
      case (pat)
         0: return ch * 61 + 3;
         1: case (ch % 4)
               0: return -1;
               1: return 2043 + (ch / 4) % 4;
               2: return ch;
               default: return 1500 + ch;
            endcase
         default: return (ch % 2 == 1) ? 0 : 1000;
      endcase
   endfunction

   function automatic int expw(input int pat, input int ch);
      int t = thr(pat, ch);
      if (t < 0) return FULL;
      return (t + 2 > FULL) ? FULL : t + 2;
   endfunction

   task automatic convert(input int pat, input bit poke);
      int bad_ramp = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int j = 0; j < SWEEP; j++) begin
         if (!ramp_on || done) bad_ramp++;
         for (int ch = 0; ch < NCH; ch++) begin
            int t = thr(pat, ch);
            if (t >= 0) begin
               if (j == t)     cmp[ch] = 1'b1;
               if (j == t + 4) cmp[ch] = 1'b0;   // R4 glitch, second rise below
               if (j == t + 8) cmp[ch] = 1'b1;
            end
         end
         start = (poke && j == 100);             // R9 start during sweep
         @(negedge clk);
      end
      start = 1'b0;
      chk(bad_ramp == 0, "R2 ramp high for full sweep", bad_ramp, 0);
      chk(!ramp_on, "R2 ramp low after 2048 cycles", ramp_on, 0);
      chk(done, poke ? "R9 done timing with ignored start" : "R6 done after sweep", done, 1);
   endtask

   task automatic drain(input int pat, input bit pause);
      for (int b = 0; b < LBITS; b++) begin
         for (int k = 0; k < NLANE; k++) got[k][LBITS-1-b] = sdata[k];
         if (b == 1) chk(!done, "R6 done one cycle", done, 0);
         if (pause && b == 40) begin
            logic [NLANE-1:0] held = sdata;
            rd_en = 1'b0;
            for (int p = 0; p < 3; p++) begin
               start = (p == 0);
               @(negedge clk);
               chk(sdata == held, "R8 lanes hold without read enable", sdata, held);
               chk(!ramp_on, "R9 start ignored during shift-out", ramp_on, 0);
            end
            start = 1'b0;
         end
         rd_en = 1'b1;
         @(negedge clk);
      end
      rd_en = 1'b0;
      chk(sdata == '0, "R7 lanes empty after 88 shifts", sdata, 0);
      for (int k = 0; k < NLANE; k++) begin
         for (int w = 0; w < WPL; w++) begin
            int ch = k * WPL + w;
            int v  = int'(got[k][LBITS-1-w*CW -: CW]);
            int e  = expw(pat, ch);
            chk(v == e, (thr(pat, ch) < 0) ? "R5 unfired channel full scale"
                        : "R3 R4 R7 captured code and lane order", v, e);
         end
      end
      cmp = '0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!ramp_on, "R1 ramp low in reset", ramp_on, 0);
      chk(!done, "R1 done low in reset", done, 0);
      chk(sdata == '0, "R1 lanes low in reset", sdata, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      convert(0, 1'b0); drain(0, 1'b0);
      convert(1, 1'b1); drain(1, 1'b1);
      convert(2, 1'b0); drain(2, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule